// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block applies the SHA-256 compression function to one 512-bit message block at a time and holds the running 256-bit hash between blocks. The caller pads the message itself and then feeds the padded blocks in order. The first block of a message is started with `cmd_init`, which loads the standard initial hash words. Each later block is started with `cmd_next`, which carries on from the hash that the previous block produced. When the last block has finished, the digest is read from the wide output.

When a strobe is accepted, the block input is copied into the message-schedule registers. The caller may therefore change `block` at once. The controller walks four named states. In `ST_IDLE` it waits for a strobe. In `ST_SETUP` it copies the hash into the working variables a..h. In `ST_ROUNDS` it runs 64 rounds, one per clock, with round constants taken from a read-only table indexed by the round number. In `ST_FINAL` it adds each working variable into its hash word. The transitions are:
- IDLE→SETUP on an accepted strobe.
- SETUP→ROUNDS always.
- ROUNDS→ROUNDS until round 63, then ROUNDS→FINAL.
- FINAL→IDLE always.

Every sum in the round and in the final update has its own adder.

Top module: `sha256_engine`

## Requirements
- R1: After reset, `ready` is 1 and `digest_valid` is 0.
- R2: A block accepted with `cmd_init` is compressed starting from the standard SHA-256 initial hash. `block[511:480]` is message word 0 and `digest[255:224]` is hash word 0. A single padded block then yields its standard SHA-256 digest.
- R3: A block accepted with `cmd_next` is compressed starting from the hash that the previous block left. An init block followed by a next block yields the standard digest of the two-block message.
- R4: The block input is captured on the accepting edge. Changes to `block` after that edge do not affect the result.
- R5: `ready` is low from the cycle after an accepted strobe. It returns high exactly 66 cycles after the accepting edge: 1 setup cycle, 64 round cycles and 1 finalize cycle.
- R6: A strobe that arrives while `ready` is low is ignored. The digest and the latency of the block in flight are unchanged.
- R7: `digest_valid` falls in the cycle after an accepted `cmd_init`. It is 1 when `ready` returns, and it stays 1 while a `cmd_next` block is processed.
- R8: If `cmd_init` and `cmd_next` are both high when a strobe is accepted, `cmd_init` takes effect.
- R9: While the block is idle and no strobe is accepted, `digest` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_init | input | 1 | Start a new message with this block |
| cmd_next | input | 1 | Continue the message with this block |
| block | input | 512 | Padded message block, word 0 in the top bits |
| ready | output | 1 | Idle; able to accept a strobe |
| digest | output | 256 | Running hash, word 0 in the top bits |
| digest_valid | output | 1 | The digest holds a finished result |

## Verification
The checker runs on every cycle. It covers the busy/idle handshake:
- an accepted strobe drops `ready`;
- a cycle counter requires every busy period to last exactly 66 cycles;
- an init clears `digest_valid`, and a next leaves it set;
- `digest_valid` only rises together with `ready`;
- the digest holds steady while the block is idle.

Whether the hash values are correct can only be shown by the bench's scenarios, which use known-answer messages. The same applies to chaining across blocks, to capture of the block input, to strobes ignored while busy, and to init taking priority over next.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
    localparam int WORD_W   = 32;
    localparam int NUM_WORK = 8;
    localparam int BLOCK_W  = 16 * WORD_W;
    localparam int HASH_W   = NUM_WORK * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } work_t;

    localparam work_t HASH_IV = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction
endpackage

// File: rtl/sha256_kconst.sv
module sha256_kconst
    import sha256_pkg::*;
#(
    parameter int ROUNDS = 64,
    localparam int IDX_W = $clog2(ROUNDS)
) (
    input  logic [IDX_W-1:0] idx,
    output word_t            k
);
    localparam word_t K_TAB [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    assign k = K_TAB[idx];
endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
    import sha256_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BLOCK_W-1:0] block,
    input  logic               advance,
    output word_t              w_out
);
    word_t win_q [DEPTH];
    word_t w_new;

    // window holds W[t..t+15]; the word shifted in is W[t+16]
    assign w_new = small_sig1(win_q[DEPTH-2]) + win_q[DEPTH-7]
                 + small_sig0(win_q[1]) + win_q[0];
    assign w_out = win_q[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_q[i] <= '0;
            end else if (load) begin
                win_q[i] <= block[BLOCK_W-1-WORD_W*i -: WORD_W];
            end else if (advance) begin
                if (i == DEPTH-1) win_q[i] <= w_new;
                else              win_q[i] <= win_q[(i+1) % DEPTH];
            end
        end
    end
endmodule

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_pkg::*;
(
    input  work_t cur,
    input  word_t k,
    input  word_t w,
    output work_t nxt
);
    word_t s1_sum, ch_sum, k_sum, t1, t2;

    assign s1_sum = cur.h + big_sig1(cur.e);
    assign ch_sum = s1_sum + choose(cur.e, cur.f, cur.g);
    assign k_sum  = ch_sum + k;
    assign t1     = k_sum + w;
    assign t2     = big_sig0(cur.a) + majority(cur.a, cur.b, cur.c);

    always_comb begin
        nxt   = cur;
        nxt.h = cur.g;
        nxt.g = cur.f;
        nxt.f = cur.e;
        nxt.e = cur.d + t1;
        nxt.d = cur.c;
        nxt.c = cur.b;
        nxt.b = cur.a;
        nxt.a = t1 + t2;
    end
endmodule

// File: rtl/sha256_engine.sv
module sha256_engine
    import sha256_pkg::*;
#(
    parameter int ROUNDS = 64,
    localparam int CNT_W = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_init,
    input  logic               cmd_next,
    input  logic [BLOCK_W-1:0] block,
    output logic               ready,
    output logic [HASH_W-1:0]  digest,
    output logic               digest_valid
);
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ROUNDS, ST_FINAL} state_t;

    state_t           state_q, state_d;
    logic [CNT_W-1:0] round_q;
    work_t            work_q, work_nxt, hash_q;
    logic [HASH_W-1:0] hash_sum;
    word_t            k_word, w_word;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && (cmd_init || cmd_next);

    sha256_kconst #(.ROUNDS(ROUNDS)) u_kconst (
        .idx (round_q),
        .k   (k_word)
    );

    sha256_sched u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .block   (block),
        .advance (state_q == ST_ROUNDS),
        .w_out   (w_word)
    );

    sha256_round u_round (
        .cur (work_q),
        .k   (k_word),
        .w   (w_word),
        .nxt (work_nxt)
    );

    for (genvar i = 0; i < NUM_WORK; i++) begin : g_final_add
        assign hash_sum[WORD_W*i +: WORD_W] =
            hash_q[WORD_W*i +: WORD_W] + work_q[WORD_W*i +: WORD_W];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_ROUNDS;
            ST_ROUNDS: if (round_q == CNT_W'(ROUNDS-1)) state_d = ST_FINAL;
            ST_FINAL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            round_q      <= '0;
            work_q       <= '0;
            hash_q       <= '0;
            digest_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && cmd_init) begin
                        hash_q       <= HASH_IV;
                        digest_valid <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    work_q  <= hash_q;
                    round_q <= '0;
                end
                ST_ROUNDS: begin
                    work_q  <= work_nxt;
                    round_q <= round_q + 1'b1;
                end
                ST_FINAL: begin
                    hash_q       <= hash_sum;
                    digest_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ready  = (state_q == ST_IDLE);
    assign digest = hash_q;
endmodule

// File: rtl/sha256_engine_chk.sv
module sha256_engine_chk #(
    parameter int LAT    = 66,
    parameter int HASH_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_init,
    input logic              cmd_next,
    input logic              ready,
    input logic              digest_valid,
    input logic [HASH_W-1:0] digest
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= '0;
        else if (ready) busy_cnt <= '0;
        else            busy_cnt <= busy_cnt + 1'b1;
    end

    // R5
    strobe_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && (cmd_init || cmd_next) |=> !ready);

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> busy_cnt == 16'(LAT));

    // R7
    init_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cmd_init |=> !digest_valid);

    // R7
    next_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cmd_next && !cmd_init && digest_valid |=> digest_valid);

    // R7
    valid_rises_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digest_valid) |-> $rose(ready));

    // R9
    idle_digest_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !cmd_init && !cmd_next |=> $stable(digest));
endmodule

bind sha256_engine sha256_engine_chk #(.LAT(ROUNDS + 2), .HASH_W(sha256_pkg::HASH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_init     (cmd_init),
    .cmd_next     (cmd_next),
    .ready        (ready),
    .digest_valid (digest_valid),
    .digest       (digest)
);

// File: tb/sha256_engine_tb.sv
module sha256_engine_tb;
    localparam int LAT = 66;

    typedef struct {
        logic         check_digest;
        logic [255:0] digest;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_init = 1'b0;
    logic         cmd_next = 1'b0;
    logic [511:0] block = '0;
    logic         ready;
    logic [255:0] digest;
    logic         digest_valid;

    int   n_checks = 0;
    int   n_fails = 0;
    exp_t exp_q[$];
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    sha256_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_init     (cmd_init),
        .cmd_next     (cmd_next),
        .block        (block),
        .ready        (ready),
        .digest       (digest),
        .digest_valid (digest_valid)
    );

    localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
    localparam logic [511:0] BLK_ABC   = {32'h61626380, 448'h0, 32'h00000018};
    localparam logic [511:0] BLK_TWO_A = {
        32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
        32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
        32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
        32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam logic [511:0] BLK_TWO_B = {480'h0, 32'h000001c0};

    localparam logic [255:0] D_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    localparam logic [255:0] D_ABC   = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] D_TWO   = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: wait for idle, push expectation, pulse the strobe, then scramble the input
    task automatic send(input bit do_init, input bit do_next, input logic [511:0] blk,
                        input bit chk, input logic [255:0] exp_d, input string tag);
        exp_t e;
        bit   was_valid;
        while (!ready) @(negedge clk);
        was_valid = digest_valid;
        e.check_digest = chk;
        e.digest = exp_d;
        e.tag = tag;
        exp_q.push_back(e);
        block = blk;
        cmd_init = do_init;
        cmd_next = do_next;
        @(negedge clk);
        cmd_init = 1'b0;
        cmd_next = 1'b0;
        block = {16{32'hdeadbeef}};  // R4: input changed right after capture
        // R5: ready low in the cycle after the accepting edge
        check(ready == 1'b0, "R5 ready low after strobe", 256'(ready), 256'd0);
        if (do_init)
            check(digest_valid == 1'b0, "R7 valid cleared by init", 256'(digest_valid), 256'd0);
        else if (was_valid)
            check(digest_valid == 1'b1, "R7 valid held during next", 256'(digest_valid), 256'd1);
    endtask

    // monitor: count busy cycles, compare on every return to idle
    int busy_cycles = 0;
    bit ready_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ready) busy_cycles++;
            if (ready && !ready_prev) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected completion", 256'd0, 256'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(busy_cycles == LAT, {"R5 latency ", e.tag}, 256'(busy_cycles), 256'(LAT));
                    check(digest_valid == 1'b1, {"R7 valid at done ", e.tag}, 256'(digest_valid), 256'd1);
                    if (e.check_digest)
                        check(digest == e.digest, e.tag, digest, e.digest);
                end
                busy_cycles = 0;
            end
            ready_prev = ready;
        end
    end

    initial begin
        logic [255:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready == 1'b1, "R1 ready after reset", 256'(ready), 256'd1);
        check(digest_valid == 1'b0, "R1 valid after reset", 256'(digest_valid), 256'd0);
        rst_n = 1'b1;
        @(negedge clk);

        send(1, 0, BLK_EMPTY, 1, D_EMPTY, "R2 empty message");
        send(1, 0, BLK_ABC, 1, D_ABC, "R2 R4 abc message");

        // R6: strobes while busy are ignored
        send(1, 0, BLK_TWO_A, 1, D_ABC, "R6 abc with busy strobes");
        // this call started TWO_A with init: fix expectation by recovering below
        void'(exp_q.pop_back());
        exp_q.push_back('{1'b0, 256'd0, "R6 placeholder"});
        repeat (10) @(negedge clk);
        block = BLK_EMPTY;
        cmd_next = 1'b1;
        @(negedge clk);
        cmd_next = 1'b0;
        cmd_init = 1'b1;
        @(negedge clk);
        cmd_init = 1'b0;
        send(0, 1, BLK_TWO_B, 1, D_TWO, "R3 R6 two-block chain");

        // R9: digest unchanged while idle
        while (!ready) @(negedge clk);
        held = digest;
        repeat (5) @(negedge clk);
        check(digest == held, "R9 digest stable when idle", digest, held);

        // R8: init wins over next
        send(1, 1, BLK_ABC, 1, D_ABC, "R8 init and next together");

        // R2: a fresh init after a chain starts over
        send(1, 0, BLK_EMPTY, 1, D_EMPTY, "R2 restart after chain");

        while (!ready || exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule